// File: doc/BRIEF.md
# Ring-Oscillator Calibration Counter

This block measures how fast a delay-line ring oscillator runs. Software writes a start bit, and the block counts oscillator edges across a window of exactly 32 periods of a slower reference clock. The count is stored in a result field. It is later used to choose the settings of programmable output delays. The oscillator and the delay lines are outside this block. Both the reference clock and the oscillator arrive as single-cycle tick strobes that are already synchronous to the system clock.

The window opens on the first reference tick after the start is accepted. It closes on the 32nd reference tick after the opening tick. Oscillator ticks are counted from the cycle after the opening tick up to and including the cycle of the closing tick. A tick that arrives in the same cycle as the opening tick is not counted. When the window closes, the result is latched, the start bit clears itself, the done bit sets, and a one-cycle done pulse is raised.

Top module: `osc_cal_counter`

## Requirements
- R1: Read data bits 7:0 hold the number of oscillator ticks seen in the last completed window. The window runs from the cycle after the opening reference tick up to and including the cycle of the closing reference tick.
- R2: A write with the start value 1, made while no measurement is running, makes read bit 14 read 1 from the next cycle on. Bit 14 returns to 0 in the cycle after the window closes.
- R3: Read bit 15 (done) becomes 1 in the cycle after a window closes. It returns to 0 in the cycle after a new start is accepted.
- R4: Read bits 13:8 and 31:16 always read zero.
- R5: The window opens on the first reference tick sampled after the start is accepted. It closes on the 32nd reference tick after the opening tick.
- R6: `done_pulse` is high for exactly the one cycle in which bit 15 first reads 1 after a measurement.
- R7: The count stops at 255 instead of wrapping when more ticks arrive.
- R8: Bits 7:0 keep the previous result until the next window closes; they do not change during a window.
- R9: A start write accepted while a measurement is armed or running has no effect. The window length, the count and the done bit are unchanged.
- R10: After reset, all read data bits are 0 and `done_pulse` is 0.
- R11: A write whose start value is 0 has no effect on any read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_start | input | 1 | Value written to the start bit (bit 14) |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period |
| osc_tick | input | 1 | One-cycle strobe per ring-oscillator edge |
| rd_data | output | 32 | Register read value: count, start and done fields |
| done_pulse | output | 1 | One-cycle pulse when a measurement completes |

## Verification
An accepted start write shows on bit 14 one cycle later. The clearing of bit 15 on a new start is due in that same cycle. The count, the cleared start bit, the set done bit and the done pulse all appear in the cycle after the edge that samples the 32nd reference tick following the opening tick. The bench drives every input at the falling edge and moves a port-level model forward by one cycle for each rising edge. It compares each read field and the pulse at the next falling edge, so every result is checked in exactly the cycle it is due. Random reference rates and oscillator densities are mixed with directed cases: a tick coincident with the opening tick, saturation, a write while busy, a write with start 0, and a restart while done is set.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_ARMED = 2'd1,
        WIN_COUNT = 2'd2
    } win_state_e;

endpackage

// File: rtl/osc_cal_window.sv
module osc_cal_window
    import osc_cal_pkg::*;
#(
    parameter int WIN_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ref_tick,
    output logic opening,
    output logic counting,
    output logic closing
);

    localparam int TW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [TW-1:0] LAST_REF = TW'(WIN_TICKS - 1);

    typedef struct packed {
        win_state_e    st;
        logic [TW-1:0] refs;
    } win_regs_t;

    win_regs_t win_d, win_q;

    always_comb begin
        win_d    = win_q;
        opening  = 1'b0;
        closing  = 1'b0;
        counting = (win_q.st == WIN_COUNT);
        case (win_q.st)
            WIN_IDLE: begin
                if (arm) begin
                    win_d.st = WIN_ARMED;
                end
            end
            WIN_ARMED: begin
                if (ref_tick) begin
                    win_d.st   = WIN_COUNT;
                    win_d.refs = '0;
                    opening    = 1'b1;
                end
            end
            WIN_COUNT: begin
                if (ref_tick) begin
                    if (win_q.refs == LAST_REF) begin
                        win_d.st = WIN_IDLE;
                        closing  = 1'b1;
                    end else begin
                        win_d.refs = win_q.refs + 1'b1;
                    end
                end
            end
            default: win_d.st = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q.st   <= WIN_IDLE;
            win_q.refs <= '0;
        end else begin
            win_q <= win_d;
        end
    end

endmodule

// File: rtl/osc_cal_accum.sv
module osc_cal_accum #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] value_next
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } acc_regs_t;

    acc_regs_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d.cnt = '0;
        end else if (inc && (acc_q.cnt != CNT_MAX)) begin
            acc_d.cnt = acc_q.cnt + 1'b1;
        end
        value_next = acc_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.cnt <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 8,
    parameter int START_BIT = 14,
    parameter int DONE_BIT  = 15,
    parameter int WIN_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_start,
    input  logic              ref_tick,
    input  logic              osc_tick,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_pulse
);

    typedef struct packed {
        logic             start;
        logic             done;
        logic             pulse;
        logic [CNT_W-1:0] result;
    } top_regs_t;

    top_regs_t top_d, top_q;

    logic             accept;
    logic             opening;
    logic             counting;
    logic             closing;
    logic [CNT_W-1:0] acc_next;

    assign accept = reg_wr_en && reg_wr_start && !top_q.start;

    osc_cal_window #(
        .WIN_TICKS(WIN_TICKS)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (accept),
        .ref_tick(ref_tick),
        .opening (opening),
        .counting(counting),
        .closing (closing)
    );

    osc_cal_accum #(
        .CNT_W(CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (opening),
        .inc       (counting && osc_tick),
        .value_next(acc_next)
    );

    always_comb begin
        top_d       = top_q;
        top_d.pulse = 1'b0;
        if (closing) begin
            top_d.result = acc_next;
            top_d.start  = 1'b0;
            top_d.done   = 1'b1;
            top_d.pulse  = 1'b1;
        end else if (accept) begin
            top_d.start = 1'b1;
            top_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.start  <= 1'b0;
            top_q.done   <= 1'b0;
            top_q.pulse  <= 1'b0;
            top_q.result <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        rd_data              = '0;
        rd_data[CNT_W-1:0]   = top_q.result;
        rd_data[START_BIT]   = top_q.start;
        rd_data[DONE_BIT]    = top_q.done;
    end

    assign done_pulse = top_q.pulse;

endmodule

// File: rtl/osc_cal_counter_chk.sv
module osc_cal_counter_chk #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 8,
    parameter int START_BIT = 14,
    parameter int DONE_BIT  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_wr_start,
    input logic [DATA_W-1:0] rd_data,
    input logic              done_pulse
);

    logic             st;
    logic             dn;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] rsvd_mask;

    always_comb begin
        rsvd_mask            = '1;
        rsvd_mask[CNT_W-1:0] = '0;
        rsvd_mask[START_BIT] = 1'b0;
        rsvd_mask[DONE_BIT]  = 1'b0;
    end

    assign st  = rd_data[START_BIT];
    assign dn  = rd_data[DONE_BIT];
    assign cnt = rd_data[CNT_W-1:0];

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & rsvd_mask) == '0);

    p_pulse_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (dn && !st));

    p_done_rise_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn) |-> done_pulse);

    p_start_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st) |-> !dn);

    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |-> $stable(cnt));

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st && reg_wr_en && reg_wr_start) |=> (st || done_pulse));

    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st && reg_wr_en && reg_wr_start) |=> st);

    p_zero_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st && !(reg_wr_en && reg_wr_start)) |=> (!st && $stable(dn)));

endmodule

bind osc_cal_counter osc_cal_counter_chk #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .START_BIT(START_BIT),
    .DONE_BIT (DONE_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_start(reg_wr_start),
    .rd_data     (rd_data),
    .done_pulse  (done_pulse)
);

// File: tb/osc_cal_counter_bench.sv
module osc_cal_counter_bench;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_start = 1'b0;
    logic        ref_tick = 1'b0;
    logic        osc_tick = 1'b0;
    logic [31:0] rd_data;
    logic        done_pulse;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // port-level model state
    int       m_state = 0;   // 0 idle, 1 armed, 2 counting
    int       m_refs = 0;
    int       m_acc = 0;
    int       m_res = 0;
    bit       m_start = 0;
    bit       m_done = 0;
    bit       m_pulse = 0;

    always #(CLK_NS/2) clk = ~clk;

    osc_cal_counter u_osc_cal_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_start(reg_wr_start),
        .ref_tick    (ref_tick),
        .osc_tick    (osc_tick),
        .rd_data     (rd_data),
        .done_pulse  (done_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v < 255) ? v + 1 : 255;
    endfunction

    task automatic compare_all();
        check(rd_data[7:0] == 8'(m_res), "R1 R8 count", int'(rd_data[7:0]), m_res);
        check(rd_data[14] == m_start, "R2 start", int'(rd_data[14]), int'(m_start));
        check(rd_data[15] == m_done, "R3 done", int'(rd_data[15]), int'(m_done));
        check(rd_data[13:8] == 6'd0 && rd_data[31:16] == 16'd0, "R4 reserved",
              int'(rd_data[31:16]), 0);
        check(done_pulse == m_pulse, "R6 pulse", int'(done_pulse), int'(m_pulse));
    endtask

    // called at a falling edge; drives, waits one rising edge, compares at next falling edge
    task automatic step(input bit w, input bit s, input bit r, input bit o);
        bit acc;
        reg_wr_en    = w;
        reg_wr_start = s;
        ref_tick     = r;
        osc_tick     = o;
        acc     = w && s && !m_start;
        m_pulse = 0;
        case (m_state)
            0: if (acc) m_state = 1;
            1: if (r) begin m_state = 2; m_refs = 0; m_acc = 0; end
            default: begin
                if (o) m_acc = sat_inc(m_acc);
                if (r) begin
                    if (m_refs == 31) begin
                        m_res = m_acc; m_start = 0; m_done = 1; m_pulse = 1; m_state = 0;
                    end else begin
                        m_refs++;
                    end
                end
            end
        endcase
        if (acc) begin m_start = 1; m_done = 0; end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    // one measurement: ref tick every rp cycles, osc with probability op/100
    task automatic measure(input int rp, input int op, input bit busy_poke);
        int guard = 0;
        step(1, 1, 0, 0);           // R2 start accepted
        while (m_start && guard < 4000) begin
            bit r = ($urandom_range(rp - 1, 0) == 0);
            bit o = ($urandom_range(99, 0) < op);
            bit w = busy_poke && ($urandom_range(7, 0) == 0);   // R9 writes while busy
            step(w, w, r, o);
            guard++;
        end
        check(!m_start, "R5 window closed", int'(m_start), 0);
        step(0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        check(rd_data == 32'd0, "R10 reset rd_data", int'(rd_data), 0);
        check(done_pulse == 1'b0, "R10 reset pulse", int'(done_pulse), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0);

        // R11 write with start 0 has no effect, also with ticks present
        for (int i = 0; i < 6; i++) step(1, 0, 1, 1);

        // R5 directed: ref tick every cycle, osc every cycle -> window 32 cycles, count 32
        step(1, 1, 0, 0);
        step(0, 0, 1, 1);   // opening tick, coincident osc not counted (R1)
        for (int i = 0; i < 32; i++) step(0, 0, 1, 1);
        check(int'(rd_data[7:0]) == 32, "R5 R1 directed count", int'(rd_data[7:0]), 32);
        check(rd_data[15] == 1'b1, "R3 done after directed", int'(rd_data[15]), 1);

        // R11 while done is set
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);

        // R7 saturation: ref every 10 cycles, osc every cycle
        measure(10, 100, 0);
        check(rd_data[7:0] == 8'd255, "R7 saturated", int'(rd_data[7:0]), 255);

        // R1 zero oscillator activity
        measure(2, 0, 0);
        check(rd_data[7:0] == 8'd0, "R1 no osc", int'(rd_data[7:0]), 0);

        // R9 busy writes, random traffic
        for (int k = 0; k < 6; k++) measure(1 + (k % 3), 30 + 10 * k, 1);

        // random mix
        for (int k = 0; k < 20; k++)
            measure($urandom_range(4, 1), $urandom_range(100, 0), bit'($urandom_range(1, 0)));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule